// File: doc/BRIEF.md
# Framebuffer Control and Status Register Window with Frame Interrupt

This block is the small register window of a framebuffer controller. It holds a control byte, a status byte and a bank of general storage bytes that software uses for cursor limits and video settings. The window is 32 bytes wide and is reached through a simple byte-addressed port that moves one to four bytes per access.

Once per frame the video side pulses an end-of-frame strobe. If the interrupt enable in the control byte is set, the block latches a sticky pending flag and drives a level interrupt. Software clears both by writing anything to the status byte. Reads of the status byte always carry fixed identity bits next to the pending flag. The lower half of the window belongs to palette logic held elsewhere, so reads there return zero and writes there change nothing.

Top module: `fbc_regwin`

## Requirements
- R1: After reset the interrupt is low, the control byte and all storage bytes read 0x00, and the status byte reads 0x61.
- R2: Offset 0x10 is the control byte. It is readable and writable in all 8 bits, and bit 7 enables the frame interrupt.
- R3: Offsets 0x12 to 0x1F are storage bytes. Each returns the last value written to it.
- R4: A status read at offset 0x11 returns 0x61 OR (pending << 7). Bits 6..0 never change.
- R5: An end-of-frame pulse sampled while control bit 7 is 1 makes irq high from the next cycle on. While bit 7 is 0 the pulse has no effect.
- R6: The pending flag is sticky. irq stays high until the status byte is written, even if control bit 7 is cleared in the meantime.
- R7: Any write whose bytes include offset 0x11 clears the pending flag and lowers irq on the next cycle, whatever data is written. Other bytes of the same access still write normally.
- R8: If an end-of-frame pulse with interrupts enabled meets a status write in the same cycle, the pending flag stays set.
- R9: Offsets 0x00 to 0x0F read as zero, and writes to them change no readable state.
- R10: An access has size code s (0..3), which means s+1 bytes. Byte k of the access goes to offset addr+k and travels on data bits 8k+7..8k. Data lanes above the size, and offsets beyond 0x1F, read zero and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the current access |
| addr | input | 5 | Byte offset of the first byte of the access |
| size | input | 2 | Access size code: bytes = size + 1 |
| wdata | input | 32 | Write data, byte k on lane k |
| rdata | output | 32 | Read data for addr/size, combinational |
| eof | input | 1 | End-of-frame strobe, one cycle per frame |
| irq | output | 1 | Level interrupt, mirrors the pending flag |

## Verification
A wrong pending flag shows up on irq one clock after the strobe or acknowledge that caused it. It also appears at once in bit 7 of a status read, so a lost acknowledge or a missed frame event is visible within a cycle. A lane decode error sends a byte to the wrong offset, and the bench exposes it by reading the whole window back after every sized write. Corrupt storage or control state stays visible to every later read of that offset until it is rewritten.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
   localparam int unsigned BYTE_W = 8;

   // identity bits always present in status reads
   localparam logic [7:0] FBC_ID_MON_1152 = 8'h60;
   localparam logic [7:0] FBC_ID_COLOUR   = 8'h01;
   localparam logic [7:0] FBC_STAT_ID     = FBC_ID_MON_1152 | FBC_ID_COLOUR;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_TRI   = 2'd2,
      SZ_WORD  = 2'd3
   } fbc_size_e;
endpackage

// File: rtl/fbc_lane_decode.sv
module fbc_lane_decode #(
   parameter int unsigned AW    = 5,
   parameter int unsigned LANES = 4,
   parameter int unsigned SZW   = 2,
   parameter int unsigned OFSW  = AW + 1
) (
   input  logic [AW-1:0]               addr,
   input  logic [SZW-1:0]              size,
   output logic [LANES-1:0][OFSW-1:0]  lane_ofs,
   output logic [LANES-1:0]            lane_act
);
   localparam int unsigned WIN_BYTES = 1 << AW;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      always_comb begin
         lane_ofs[k] = {1'b0, addr} + OFSW'(k);
         lane_act[k] = (SZW'(k) <= size) && (lane_ofs[k] < OFSW'(WIN_BYTES));
      end
   end
endmodule

// File: rtl/fbc_store_bank.sv
module fbc_store_bank #(
   parameter int unsigned LANES    = 4,
   parameter int unsigned OFSW     = 6,
   parameter int unsigned STORE_LO = 18,
   parameter int unsigned STORE_HI = 31,
   parameter int unsigned NREG     = STORE_HI - STORE_LO + 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [LANES-1:0]           lane_wr,
   input  logic [LANES-1:0][OFSW-1:0] lane_ofs,
   input  logic [8*LANES-1:0]         wdata,
   output logic [NREG-1:0][7:0]       bank_q
);
   for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic       we;
      logic [7:0] wd;

      always_comb begin
         we = 1'b0;
         wd = 8'h00;
         for (int k = 0; k < LANES; k++) begin
            if (lane_wr[k] && (lane_ofs[k] == OFSW'(STORE_LO + r))) begin
               we = 1'b1;
               wd = wdata[8*k +: 8];
            end
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n)  bank_q[r] <= 8'h00;
         else if (we) bank_q[r] <= wd;
      end
   end
endmodule

// File: rtl/fbc_irq_ctrl.sv
module fbc_irq_ctrl #(
   parameter int unsigned EN_BIT = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctrl_we,
   input  logic [7:0] ctrl_wd,
   input  logic       stat_we,
   input  logic       eof,
   output logic [7:0] ctrl_q,
   output logic       pend_q
);
   logic frame_evt;
   assign frame_evt = eof && ctrl_q[EN_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= 8'h00;
         pend_q <= 1'b0;
      end else begin
         if (ctrl_we) ctrl_q <= ctrl_wd;
         // a new frame event outranks an acknowledge in the same cycle
         if (frame_evt)                pend_q <= 1'b1;
         else if (stat_we && pend_q)   pend_q <= 1'b0;
      end
   end
endmodule

// File: rtl/fbc_regwin.sv
module fbc_regwin #(
   parameter int unsigned AW       = 5,
   parameter int unsigned LANES    = 4,
   parameter int unsigned CTRL_OFS = 16,
   parameter int unsigned STAT_OFS = 17,
   parameter int unsigned STORE_LO = 18,
   parameter int unsigned STORE_HI = 31,
   parameter int unsigned EN_BIT   = 7,
   parameter int unsigned PEND_BIT = 7,
   parameter logic [7:0]  STAT_ID  = fbc_pkg::FBC_STAT_ID,
   parameter int unsigned SZW      = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [AW-1:0]        addr,
   input  logic [SZW-1:0]       size,
   input  logic [8*LANES-1:0]   wdata,
   output logic [8*LANES-1:0]   rdata,
   input  logic                 eof,
   output logic                 irq
);
   localparam int unsigned WIN_BYTES = 1 << AW;
   localparam int unsigned OFSW      = AW + 1;
   localparam int unsigned NREG      = STORE_HI - STORE_LO + 1;

   if (LANES < 1 || LANES > 4) begin : g_bad_lanes
      $error("fbc_regwin: LANES must be 1..4");
   end
   if (STORE_HI >= WIN_BYTES || STORE_LO > STORE_HI) begin : g_bad_store
      $error("fbc_regwin: storage range outside window");
   end
   if (CTRL_OFS == STAT_OFS || CTRL_OFS >= STORE_LO || STAT_OFS >= STORE_LO) begin : g_bad_map
      $error("fbc_regwin: control/status must be distinct and below storage");
   end
   if (EN_BIT > 7 || PEND_BIT > 7 || STAT_ID[PEND_BIT]) begin : g_bad_bits
      $error("fbc_regwin: bad bit positions");
   end

   logic [LANES-1:0][OFSW-1:0] lane_ofs;
   logic [LANES-1:0]           lane_act;
   logic [LANES-1:0]           lane_wr;
   logic [NREG-1:0][7:0]       bank_q;
   logic [7:0]                 ctrl_q;
   logic                       pend_q;
   logic                       ctrl_we;
   logic [7:0]                 ctrl_wd;
   logic                       stat_we;
   logic [7:0]                 stat_rd;

   fbc_lane_decode #(.AW(AW), .LANES(LANES), .SZW(SZW), .OFSW(OFSW)) u_dec (
      .addr     (addr),
      .size     (size),
      .lane_ofs (lane_ofs),
      .lane_act (lane_act)
   );

   assign lane_wr = lane_act & {LANES{wr_en}};

   always_comb begin
      ctrl_we = 1'b0;
      ctrl_wd = 8'h00;
      stat_we = 1'b0;
      for (int k = 0; k < LANES; k++) begin
         if (lane_wr[k] && lane_ofs[k] == OFSW'(CTRL_OFS)) begin
            ctrl_we = 1'b1;
            ctrl_wd = wdata[8*k +: 8];
         end
         if (lane_wr[k] && lane_ofs[k] == OFSW'(STAT_OFS)) stat_we = 1'b1;
      end
   end

   fbc_store_bank #(.LANES(LANES), .OFSW(OFSW), .STORE_LO(STORE_LO),
                    .STORE_HI(STORE_HI), .NREG(NREG)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .lane_wr  (lane_wr),
      .lane_ofs (lane_ofs),
      .wdata    (wdata),
      .bank_q   (bank_q)
   );

   fbc_irq_ctrl #(.EN_BIT(EN_BIT)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_we (ctrl_we),
      .ctrl_wd (ctrl_wd),
      .stat_we (stat_we),
      .eof     (eof),
      .ctrl_q  (ctrl_q),
      .pend_q  (pend_q)
   );

   assign stat_rd = STAT_ID | (8'(pend_q) << PEND_BIT);
   assign irq     = pend_q;

   for (genvar k = 0; k < LANES; k++) begin : g_rd
      always_comb begin
         rdata[8*k +: 8] = 8'h00;
         if (lane_act[k]) begin
            if (lane_ofs[k] == OFSW'(CTRL_OFS))      rdata[8*k +: 8] = ctrl_q;
            else if (lane_ofs[k] == OFSW'(STAT_OFS)) rdata[8*k +: 8] = stat_rd;
            else begin
               for (int r = 0; r < NREG; r++) begin
                  if (lane_ofs[k] == OFSW'(STORE_LO + r)) rdata[8*k +: 8] = bank_q[r];
               end
            end
         end
      end
   end
endmodule

// File: rtl/fbc_regwin_chk.sv
module fbc_regwin_chk #(
   parameter int unsigned AW       = 5,
   parameter int unsigned LANES    = 4,
   parameter int unsigned SZW      = 2,
   parameter int unsigned CTRL_OFS = 16,
   parameter int unsigned STAT_OFS = 17,
   parameter int unsigned PEND_BIT = 7,
   parameter logic [7:0]  STAT_ID  = 8'h61
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [AW-1:0]      addr,
   input logic [SZW-1:0]     size,
   input logic [8*LANES-1:0] rdata,
   input logic               eof,
   input logic               irq,
   input logic               ctrl_en,
   input logic               stat_wr
);
   logic [7:0] stat_exp;
   logic       evt;
   assign stat_exp = STAT_ID | (8'(irq) << PEND_BIT);
   assign evt      = eof && ctrl_en;

   // R5
   eof_sets_chk: assert property (@(posedge clk) disable iff (!rst_n) evt |=> irq);
   // R5
   no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n) (!irq && !evt) |=> !irq);
   // R6
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) (irq && !stat_wr) |=> irq);
   // R7
   ack_chk: assert property (@(posedge clk) disable iff (!rst_n) (irq && stat_wr && !evt) |=> !irq);
   // R7
   ack_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n) stat_wr |-> wr_en);
   // R8
   collide_chk: assert property (@(posedge clk) disable iff (!rst_n) (evt && stat_wr) |=> irq);
   // R4
   stat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == AW'(STAT_OFS) && size == '0) |-> rdata[7:0] == stat_exp);
   // R9
   unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr < AW'(CTRL_OFS) && size == '0) |-> rdata == '0);
endmodule

bind fbc_regwin fbc_regwin_chk #(
   .AW(AW), .LANES(LANES), .SZW(SZW), .CTRL_OFS(CTRL_OFS),
   .STAT_OFS(STAT_OFS), .PEND_BIT(PEND_BIT), .STAT_ID(STAT_ID)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .size(size),
   .rdata(rdata), .eof(eof), .irq(irq), .ctrl_en(ctrl_q[EN_BIT]), .stat_wr(stat_we)
);

// File: tb/fbc_regwin_bench.sv
module fbc_regwin_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  addr = '0;
   logic [1:0]  size = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        eof = 1'b0;
   logic        irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   logic [7:0] mdl [32];
   bit pend = 1'b0;

   always #2 clk = ~clk;

   fbc_regwin u_fbc_regwin (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .size(size),
      .wdata(wdata), .rdata(rdata), .eof(eof), .irq(irq)
   );

   function automatic logic [7:0] exp_byte(input int o);
      if (o == 16) return mdl[16];
      if (o == 17) return 8'h61 | (8'(pend) << 7);
      if (o >= 18 && o <= 31) return mdl[o];
      return 8'h00;
   endfunction

   function automatic logic [31:0] exp_read(input int a, input int s);
      logic [31:0] v = '0;
      for (int k = 0; k <= s; k++) v[8*k +: 8] = exp_byte(a + k);
      return v;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one clock with optional write and frame strobe; model updated per R5..R8, R10
   task automatic step(input bit e, input bit w, input int a, input int s, input logic [31:0] d);
      bit evt = e && mdl[16][7];
      bit sw = 1'b0;
      @(negedge clk);
      eof = e; wr_en = w; addr = 5'(a); size = 2'(s); wdata = d;
      if (w) begin
         for (int k = 0; k <= s; k++) begin
            if (a + k == 16 || (a + k >= 18 && a + k <= 31)) mdl[a + k] = d[8*k +: 8];
            if (a + k == 17) sw = 1'b1;
         end
      end
      if (evt) pend = 1'b1;
      else if (sw) pend = 1'b0;
      @(negedge clk);
      eof = 1'b0; wr_en = 1'b0;
      #1;
   endtask

   task automatic rd(input string req, input int a, input int s);
      addr = 5'(a); size = 2'(s);
      #1;
      check(req, rdata, exp_read(a, s));
   endtask

   function automatic string tag_of(input int o);
      if (o == 16) return "R2";
      if (o == 17) return "R4";
      if (o >= 18) return "R3";
      return "R9";
   endfunction

   initial begin
      for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1_irq", {31'd0, irq}, 32'd0);
      for (int o = 0; o < 32; o++) rd("R1", o, 0);

      // R10 sized write sweep with full readback; R2 R3 R9 per offset
      for (int a = 0; a < 32; a++) begin
         for (int s = 0; s < 4; s++) begin
            step(1'b0, 1'b1, a, s, 32'h9E3779B9 * (a * 4 + s + 1));
            for (int o = 0; o < 32; o++) rd(tag_of(o), o, 0);
            rd("R10", a, s);
         end
      end
      for (int a = 0; a < 32; a++)
         for (int s = 0; s < 4; s++) rd("R10", a, s);

      // R5 strobe while disabled
      step(1'b0, 1'b1, 16, 0, 32'h0000_007F);
      step(1'b1, 1'b0, 0, 0, 0);
      check("R5_disabled", {31'd0, irq}, 32'd0);
      // R5 strobe while enabled
      step(1'b0, 1'b1, 16, 0, 32'h0000_0080);
      step(1'b1, 1'b0, 0, 0, 0);
      check("R5_enabled", {31'd0, irq}, 32'd1);
      rd("R4", 17, 0);
      // R6 disable keeps pending
      step(1'b0, 1'b1, 16, 0, 32'h0000_0000);
      repeat (3) step(1'b0, 1'b0, 0, 0, 0);
      check("R6_sticky", {31'd0, irq}, 32'd1);
      // R7 status write with all-ones data clears
      step(1'b0, 1'b1, 17, 0, 32'h0000_00FF);
      check("R7_ack", {31'd0, irq}, 32'd0);
      rd("R7", 17, 0);
      // R7 multi-byte write spanning status clears and writes control
      step(1'b0, 1'b1, 16, 0, 32'h0000_0080);
      step(1'b1, 1'b0, 0, 0, 0);
      check("R5_again", {31'd0, irq}, 32'd1);
      step(1'b0, 1'b1, 16, 2, 32'h00AB_0081);
      check("R7_span_irq", {31'd0, irq}, 32'd0);
      rd("R7_span", 16, 3);
      // R8 collision keeps pending
      step(1'b1, 1'b1, 17, 0, 32'h0);
      check("R8_collide", {31'd0, irq}, 32'd1);
      rd("R8", 17, 0);
      // R9 writes to low half change nothing
      step(1'b0, 1'b1, 12, 3, 32'hFFFF_FFFF);
      for (int o = 0; o < 32; o++) rd(tag_of(o) == "R9" ? "R9" : "R9_state", o, 0);
      check("R9_irq", {31'd0, irq}, 32'd1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule